// File: doc/BRIEF.md
# MMIO Register Front-End with Interrupts

This block is the register slave of a small teaching device. Each request on its bus carries an offset, a write flag, a size code and 64 bits of write data. The block checks the access size against the offset, decodes the offset, and answers reads one cycle later with a registered data word and a valid flag. Accesses of an illegal size are dropped without effect. A read of an illegal size returns all ones.

The block holds two pieces of state. The first is a 32-bit scratch word that keeps the bitwise complement of what was written to it. The second is a 32-bit interrupt status word, with one offset that sets bits and another that clears them. The level interrupt output stays high while any status bit is set.

The factorial engine and the DMA machinery live outside this block. Their register offsets are forwarded through a hook port: the block gives a write strobe, a read strobe, the offset and the data, and takes back a read word.

Top module: `mmio_irq_regs`

## Requirements
- R1: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Below offset 0x80 an access is legal only with code 2. At 0x80 and above, codes 2 and 3 are legal.
- R2: A write of an illegal size changes no state: scratch, status, the interrupt and the hook write strobe all stay as they were.
- R3: A read of an illegal size returns 64'hFFFF_FFFF_FFFF_FFFF.
- R4: A legal read of offset 0x00 returns 64'h0000_0000_0100_00ED.
- R5: A legal write to offset 0x04 stores the NOT of the low 32 data bits. A read of 0x04 returns the stored word, zero-extended.
- R6: A legal write to offset 0x60 ORs the low 32 data bits into the status word.
- R7: A legal write to offset 0x64 clears every status bit that is set in the low 32 data bits.
- R8: A legal read of offset 0x24 returns the status word, zero-extended.
- R9: irq_o is high exactly when the status word is nonzero. It changes in the cycle after the write that alters the status word.
- R10: A legal read of any offset that is not mapped returns all ones. Reads of 0x60 and 0x64 count as unmapped.
- R11: The hook offsets are 0x08, 0x20, 0x80, 0x88, 0x90 and 0x98. A legal access to one of them pulses hook_we_o (for a write) or hook_re_o (for a read) in the same cycle. A legal read of a hook offset returns the value on hook_rdata_i in that cycle.
- R12: After reset, rsp_valid_o and irq_o are low, and the scratch and status words are zero.
- R13: rsp_valid_o is high in the cycle after each read request, whether the read is legal or not, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| req_size_i | input | 2 | Size code (R1) |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 64 | Read response data |
| irq_o | output | 1 | Level interrupt |
| hook_we_o | output | 1 | Write strobe for hook offsets |
| hook_re_o | output | 1 | Read strobe for hook offsets |
| hook_addr_o | output | 12 | Offset forwarded to the hook |
| hook_wdata_o | output | 64 | Write data forwarded to the hook |
| hook_rdata_i | input | 64 | Read data from the hook |

## Verification
The assertions check on every cycle that each read request gets exactly one response in the next cycle, and that illegal reads and the identification offset return their fixed words. They also check that a set write with nonzero data raises the interrupt, that an illegal write leaves the interrupt unchanged, and that the hook write strobe fires only for legal writes. Other behaviour needs a model that remembers history, and only the bench scenarios can show it. This covers complement storage in the scratch word, bit-wise clearing through the clear offset, status readback, the interrupt falling once the last bit is cleared, and reads of unmapped offsets.

// File: rtl/mmio_irq_pkg.sv
package mmio_irq_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned REG_W  = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } size_e;

    localparam addr_t OFF_ID      = addr_t'('h00);
    localparam addr_t OFF_SCRATCH = addr_t'('h04);
    localparam addr_t OFF_STATUS  = addr_t'('h24);
    localparam addr_t OFF_SET     = addr_t'('h60);
    localparam addr_t OFF_CLR     = addr_t'('h64);
    localparam addr_t OFF_WIDE    = addr_t'('h80);

    localparam int unsigned N_HOOK = 6;
    localparam addr_t HOOK_OFFS [N_HOOK] = '{
        addr_t'('h08), addr_t'('h20), addr_t'('h80),
        addr_t'('h88), addr_t'('h90), addr_t'('h98)
    };

    localparam data_t ID_WORD   = data_t'('h0100_00ed);
    localparam data_t ALL_ONES  = '1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_SCRATCH,
        SEL_STATUS,
        SEL_SET,
        SEL_CLR,
        SEL_HOOK
    } sel_e;

    typedef struct packed {
        logic  legal;
        logic  wr;
        logic  rd;
        sel_e  sel;
    } dec_t;

    function automatic logic size_legal(addr_t a, logic [1:0] sz);
        if (a < OFF_WIDE) return sz == SZ_4B;
        return (sz == SZ_4B) || (sz == SZ_8B);
    endfunction

endpackage

// File: rtl/mmio_access_filter.sv
module mmio_access_filter
    import mmio_irq_pkg::*;
(
    input  logic       req_valid_i,
    input  logic       req_write_i,
    input  addr_t      req_addr_i,
    input  logic [1:0] req_size_i,
    output dec_t       dec_o
);
    logic [N_HOOK-1:0] hook_hit;

    for (genvar g = 0; g < N_HOOK; g++) begin : g_hook
        assign hook_hit[g] = (req_addr_i == HOOK_OFFS[g]);
    end

    always_comb begin
        dec_o.legal = req_valid_i && size_legal(req_addr_i, req_size_i);
        dec_o.wr    = dec_o.legal && req_write_i;
        dec_o.rd    = dec_o.legal && !req_write_i;
        if (|hook_hit) begin
            dec_o.sel = SEL_HOOK;
        end else begin
            case (req_addr_i)
                OFF_ID:      dec_o.sel = SEL_ID;
                OFF_SCRATCH: dec_o.sel = SEL_SCRATCH;
                OFF_STATUS:  dec_o.sel = SEL_STATUS;
                OFF_SET:     dec_o.sel = SEL_SET;
                OFF_CLR:     dec_o.sel = SEL_CLR;
                default:     dec_o.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mmio_scratch_reg.sv
module mmio_scratch_reg
    import mmio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en_i,
    input  reg_t  wdata_i,
    output reg_t  value_o
);
    always_ff @(posedge clk) begin
        if (rst)          value_o <= '0;
        else if (wr_en_i) value_o <= ~wdata_i;
    end
endmodule

// File: rtl/mmio_irq_status.sv
module mmio_irq_status
    import mmio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_en_i,
    input  logic  clr_en_i,
    input  reg_t  mask_i,
    output reg_t  status_o,
    output logic  irq_o
);
    reg_t next_status;

    always_comb begin
        next_status = status_o;
        if (set_en_i) next_status = next_status | mask_i;
        if (clr_en_i) next_status = next_status & ~mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            status_o <= next_status;
            irq_o    <= |next_status;
        end
    end
endmodule

// File: rtl/mmio_read_mux.sv
module mmio_read_mux
    import mmio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_req_i,
    input  dec_t  dec_i,
    input  reg_t  scratch_i,
    input  reg_t  status_i,
    input  data_t hook_rdata_i,
    output logic  rsp_valid_o,
    output data_t rsp_rdata_o
);
    data_t rd_value;

    always_comb begin
        rd_value = ALL_ONES;
        if (dec_i.rd) begin
            case (dec_i.sel)
                SEL_ID:      rd_value = ID_WORD;
                SEL_SCRATCH: rd_value = data_t'(scratch_i);
                SEL_STATUS:  rd_value = data_t'(status_i);
                SEL_HOOK:    rd_value = hook_rdata_i;
                default:     rd_value = ALL_ONES;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= rd_req_i;
            if (rd_req_i) rsp_rdata_o <= rd_value;
        end
    end
endmodule

// File: rtl/mmio_irq_regs.sv
module mmio_irq_regs
    import mmio_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid_i,
    input  logic        req_write_i,
    input  logic [11:0] req_addr_i,
    input  logic [1:0]  req_size_i,
    input  logic [63:0] req_wdata_i,
    output logic        rsp_valid_o,
    output logic [63:0] rsp_rdata_o,
    output logic        irq_o,
    output logic        hook_we_o,
    output logic        hook_re_o,
    output logic [11:0] hook_addr_o,
    output logic [63:0] hook_wdata_o,
    input  logic [63:0] hook_rdata_i
);
    dec_t dec;
    reg_t scratch_q;
    reg_t status_q;
    reg_t wlow;

    assign wlow = req_wdata_i[REG_W-1:0];

    mmio_access_filter filt_i (
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_size_i  (req_size_i),
        .dec_o       (dec)
    );

    mmio_scratch_reg scr_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (dec.wr && dec.sel == SEL_SCRATCH),
        .wdata_i (wlow),
        .value_o (scratch_q)
    );

    mmio_irq_status irq_i (
        .clk      (clk),
        .rst      (rst),
        .set_en_i (dec.wr && dec.sel == SEL_SET),
        .clr_en_i (dec.wr && dec.sel == SEL_CLR),
        .mask_i   (wlow),
        .status_o (status_q),
        .irq_o    (irq_o)
    );

    mmio_read_mux rmux_i (
        .clk          (clk),
        .rst          (rst),
        .rd_req_i     (req_valid_i && !req_write_i),
        .dec_i        (dec),
        .scratch_i    (scratch_q),
        .status_i     (status_q),
        .hook_rdata_i (hook_rdata_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_rdata_o  (rsp_rdata_o)
    );

    assign hook_we_o    = dec.wr && dec.sel == SEL_HOOK;
    assign hook_re_o    = dec.rd && dec.sel == SEL_HOOK;
    assign hook_addr_o  = req_addr_i;
    assign hook_wdata_o = req_wdata_i;
endmodule

// File: rtl/mmio_irq_regs_chk.sv
module mmio_irq_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        req_write_i,
    input logic [11:0] req_addr_i,
    input logic [1:0]  req_size_i,
    input logic [63:0] req_wdata_i,
    input logic        rsp_valid_o,
    input logic [63:0] rsp_rdata_o,
    input logic        irq_o,
    input logic        hook_we_o
);
    logic ok;
    assign ok = (req_addr_i < 12'h080) ? (req_size_i == 2'd2)
                                       : (req_size_i[1] == 1'b1);

    a_r13_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);

    a_r13_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

    a_r3_bad_read_ones: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i && !ok) |=> (rsp_rdata_o == '1));

    a_r4_id_word: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i && ok && req_addr_i == 12'h000)
        |=> (rsp_rdata_o == 64'h0100_00ed));

    a_r6_set_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i && ok && req_addr_i == 12'h060
         && req_wdata_i[31:0] != 32'h0) |=> irq_o);

    a_r2_bad_write_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i && !ok) |=> $stable(irq_o));

    a_r11_hook_we_legal: assert property (@(posedge clk) disable iff (rst)
        hook_we_o |-> (req_valid_i && req_write_i && ok));
endmodule

bind mmio_irq_regs mmio_irq_regs_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .irq_o       (irq_o),
    .hook_we_o   (hook_we_o)
);

// File: tb/mmio_irq_regs_tb_top.sv
module mmio_irq_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        irq;
    logic        hook_we, hook_re;
    logic [11:0] hook_addr;
    logic [63:0] hook_wdata;
    logic [63:0] hook_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_scr;
    logic [31:0] m_sts;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_irq_regs dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq),
        .hook_we_o(hook_we), .hook_re_o(hook_re), .hook_addr_o(hook_addr),
        .hook_wdata_o(hook_wdata), .hook_rdata_i(hook_rdata)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit legal_f(logic [11:0] a, logic [1:0] s);
        return (a < 12'h080) ? (s == 2'd2) : (s == 2'd2 || s == 2'd3);
    endfunction

    function automatic bit hook_f(logic [11:0] a);
        return a == 12'h08 || a == 12'h20 || a == 12'h80 ||
               a == 12'h88 || a == 12'h90 || a == 12'h98;
    endfunction

    function automatic logic [63:0] exp_read(logic [11:0] a, logic [1:0] s,
                                             logic [63:0] hd);
        if (!legal_f(a, s)) return '1;
        if (hook_f(a))      return hd;
        case (a)
            12'h00:  return 64'h0100_00ed;
            12'h04:  return {32'h0, m_scr};
            12'h24:  return {32'h0, m_sts};
            default: return '1;
        endcase
    endfunction

    task automatic do_write(logic [11:0] a, logic [1:0] s, logic [63:0] d);
        bit lg;
        lg = legal_f(a, s);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = s; req_wdata = d;
        #1;
        check(lg ? "R11 hook_we" : "R2 hook_we dropped", {63'h0, hook_we},
              {63'h0, lg && hook_f(a)});
        if (lg) begin
            if (a == 12'h04) m_scr = ~d[31:0];
            if (a == 12'h60) m_sts = m_sts | d[31:0];
            if (a == 12'h64) m_sts = m_sts & ~d[31:0];
        end
        @(negedge clk);
        req_valid = 0;
        check("R9 irq level", {63'h0, irq}, {63'h0, m_sts != 0});
        check("R13 no rsp after write", {63'h0, rsp_valid}, 64'h0);
    endtask

    task automatic do_read(string req, logic [11:0] a, logic [1:0] s);
        logic [63:0] hd;
        logic [63:0] exp;
        hd = {$urandom, $urandom};
        exp = exp_read(a, s, hd);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = s;
        req_wdata = {$urandom, $urandom}; hook_rdata = hd;
        #1;
        check("R11 hook_re", {63'h0, hook_re}, {63'h0, legal_f(a, s) && hook_f(a)});
        @(negedge clk);
        req_valid = 0;
        check("R13 rsp_valid", {63'h0, rsp_valid}, 64'h1);
        check(req, rsp_rdata, exp);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [11:0] addrs [12];
        void'($urandom(32'd7331));
        addrs = '{12'h00, 12'h04, 12'h08, 12'h20, 12'h24, 12'h60,
                  12'h64, 12'h80, 12'h88, 12'h98, 12'h10, 12'hA0};
        m_scr = 0; m_sts = 0;
        rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_size = 0;
        req_wdata = 0; hook_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R12 rsp_valid reset", {63'h0, rsp_valid}, 64'h0);
        check("R12 irq reset", {63'h0, irq}, 64'h0);
        do_read("R12 scratch reset", 12'h04, 2'd2);
        do_read("R12 status reset", 12'h24, 2'd2);

        do_read("R4 id", 12'h00, 2'd2);
        do_read("R1 R3 id 8B rejected", 12'h00, 2'd3);
        do_read("R1 R3 1B rejected", 12'h04, 2'd0);
        do_write(12'h04, 2'd2, 64'hFFFF_0000_1234_5678);
        do_read("R5 scratch inverse", 12'h04, 2'd2);
        do_write(12'h04, 2'd1, 64'h0);
        do_read("R2 scratch kept", 12'h04, 2'd2);
        do_write(12'h60, 2'd2, 64'h0000_0000_8000_0005);
        do_read("R6 R8 status set", 12'h24, 2'd2);
        do_write(12'h64, 2'd3, 64'hFFFF_FFFF);
        do_read("R2 status kept", 12'h24, 2'd2);
        do_write(12'h64, 2'd2, 64'h1);
        do_read("R7 partial clear", 12'h24, 2'd2);
        do_write(12'h64, 2'd2, 64'h8000_0004);
        check("R9 irq falls", {63'h0, irq}, 64'h0);
        do_read("R10 set offset reads ones", 12'h60, 2'd2);
        do_read("R10 unmapped", 12'h0C, 2'd2);
        do_read("R11 hook 8B", 12'h88, 2'd3);
        do_read("R1 R3 hook 2B rejected", 12'h90, 2'd1);
        do_write(12'h98, 2'd3, 64'h1);
        do_write(12'h08, 2'd3, 64'h1);

        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [1:0]  s;
            a = addrs[$urandom_range(11)];
            s = ($urandom_range(3) == 0) ? 2'($urandom) : ((a >= 12'h80 && $urandom_range(1) == 1) ? 2'd3 : 2'd2);
            if ($urandom_range(1) == 1) do_write(a, s, {$urandom, $urandom});
            else                        do_read("R1 R5 R8 R10 R11 random read", a, s);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule